// File: doc/BRIEF.md
# Mixed-Rate TDM Memory Access Sequencer

This block drives the parallel port of an external byte-wide memory that buffers a frame-based TDM serial interface. The interface carries 24 streams: streams 0 to 15 at 2.048 Mb/s with 32 slots per frame, and streams 16 to 23 at 8.192 Mb/s with 128 slots per frame. The frame is divided into 128 channel periods. In each channel period the sequencer first stores the received bytes with a group of twelve writes. After a short gap it fetches the bytes to be transmitted with a group of twelve reads.

Each group serves all eight fast streams. It also serves one quarter of the slow streams, and that quarter rotates from one channel to the next, so four consecutive channels cover all sixteen slow streams once. The memory is split into two 4 KB halves. Writes go to one half while reads normally come from the other, and the halves swap at every frame boundary.

Reads run ahead of writes by a separate channel offset for each rate. When a read runs past the end of the frame, it takes the next frame's byte from the half that is currently being written. The sequencer runs from the parallel clock and restarts the frame on a sync pulse.

Top module: `tdm_mem_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are idle: `mem_addr`=0, `mem_stb_n`=1, `mem_qual_a`=1, `mem_qual_b`=1, `wr_half`=0. The first rising edge after release outputs frame position 0 of channel 0 with write half 0.
- R2: A channel period lasts 64 clocks. Positions 0..23 form the write group (12 accesses of 2 clocks each). Positions 24..27 are an idle gap. Positions 28..51 form the read group. Positions 52..63 are idle. Outputs are registered one clock after the position they belong to.
- R3: A write access keeps `mem_qual_b`=1. In its first clock `mem_stb_n`=0 and `mem_qual_a`=0. In its second clock both are 1. The address is the same in both clocks.
- R4: A read access holds `mem_stb_n`=0, `mem_qual_b`=0 and `mem_qual_a`=1 for both of its clocks.
- R5: In each group, accesses 0..7 serve fast streams 16..23 in order. Accesses 8..11 serve slow streams 4q..4q+3, where q = channel mod 4.
- R6: Write addresses carry the write half in bit 12. Fast RX address = 0xC00 + ch*8 + (stream-16). Slow RX address = 0x800 + (ch div 4)*16 + stream.
- R7: Read addresses use a fast channel of (ch+8) mod 128 and a slow channel of (ch div 4 + 2) mod 32. Fast TX address = 0x400 + fch*8 + (stream-16). Slow TX address = 0x000 + sch*16 + stream. Bit 12 is the opposite of the write half, unless the channel sum wrapped; in that case bit 12 equals the write half.
- R8: A frame is 128 channels. The write half toggles at every frame boundary, and `wr_half` shows the half used by the writes currently on the port.
- R9: `frm_sync` high at a rising edge restarts at position 0 of channel 0 and toggles the half. A sync that falls on the last clock of a frame causes only one toggle.
- R10: In idle clocks `mem_addr` is 0 and all three controls are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_sync | input | 1 | Frame restart pulse, sampled on the rising edge |
| mem_addr | output | 13 | Memory byte address; bit 12 selects the buffer half |
| mem_stb_n | output | 1 | Access strobe, active low |
| mem_qual_a | output | 1 | First read/write qualifier (low for one clock per written byte) |
| mem_qual_b | output | 1 | Second read/write qualifier (low during reads) |
| wr_half | output | 1 | Buffer half that the writes on the port currently target |

## Verification
The bench builds the block with its default parameters: a 64-clock channel, 128 channels per frame, eight fast streams with an 8-channel read lead, and sixteen slow streams with a 2-channel lead. With these values a full frame of 8192 clocks, and the following frame in the other half, can be compared position by position against a reference trace. That comparison brings every rotation quarter, the last-channel address corners (0xFFF, 0x7FF) and both read-wrap cases into the run. Directed steps then cover a sync pulse in mid-frame, a sync on the last clock of a frame, and a reset in mid-run.

// File: rtl/tdmseq_pkg.sv
package tdmseq_pkg;

  localparam int unsigned ADDR_W = 13;

  typedef enum logic [1:0] {
    GRP_IDLE = 2'd0,
    GRP_WR   = 2'd1,
    GRP_RD   = 2'd2
  } grp_e;

  localparam logic [11:0] TX_SLOW_BASE = 12'h000;
  localparam logic [11:0] TX_FAST_BASE = 12'h400;
  localparam logic [11:0] RX_SLOW_BASE = 12'h800;
  localparam logic [11:0] RX_FAST_BASE = 12'hC00;

  // Place an in-region byte offset into the fixed half map.
  function automatic logic [ADDR_W-1:0] region_addr(input logic half,
                                                    input logic is_tx,
                                                    input logic fast,
                                                    input int unsigned off);
    logic [11:0] base;
    if (is_tx) base = fast ? TX_FAST_BASE : TX_SLOW_BASE;
    else       base = fast ? RX_FAST_BASE : RX_SLOW_BASE;
    return {half, base + 12'(off)};
  endfunction

endpackage

// File: rtl/tdmseq_timebase.sv
module tdmseq_timebase #(
  parameter int unsigned CHAN_CYC = 64,
  parameter int unsigned N_CHAN   = 128,
  parameter int unsigned POS_W    = 6,
  parameter int unsigned CH_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_sync,
  output logic [POS_W-1:0] pos,
  output logic [CH_W-1:0]  chan,
  output logic             half_cur,
  output logic             frame_bnd
);

  logic pos_last;
  logic chan_last;

  assign pos_last  = (pos == POS_W'(CHAN_CYC - 1));
  assign chan_last = (chan == CH_W'(N_CHAN - 1));
  assign frame_bnd = frm_sync | (pos_last & chan_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      chan     <= '0;
      half_cur <= 1'b0;
    end else if (frame_bnd) begin
      pos      <= '0;
      chan     <= '0;
      half_cur <= ~half_cur;
    end else if (pos_last) begin
      pos  <= '0;
      chan <= chan + 1'b1;
    end else begin
      pos <= pos + 1'b1;
    end
  end

endmodule

// File: rtl/tdmseq_slot_dec.sv
module tdmseq_slot_dec
  import tdmseq_pkg::*;
#(
  parameter int unsigned N_ACC   = 12,
  parameter int unsigned GAP_CYC = 4,
  parameter int unsigned POS_W   = 6,
  parameter int unsigned SLOT_W  = 4
) (
  input  logic [POS_W-1:0]  pos,
  output grp_e              grp,
  output logic [SLOT_W-1:0] slot,
  output logic              phase
);

  localparam int unsigned GRP_CYC  = 2 * N_ACC;
  localparam int unsigned RD_START = GRP_CYC + GAP_CYC;
  localparam int unsigned RD_END   = RD_START + GRP_CYC;

  int unsigned p;
  int unsigned q;

  always_comb begin
    p     = 32'(pos);
    q     = 0;
    grp   = GRP_IDLE;
    slot  = '0;
    phase = 1'b0;
    if (p < GRP_CYC) begin
      grp   = GRP_WR;
      slot  = SLOT_W'(p >> 1);
      phase = p[0];
    end else if (p >= RD_START && p < RD_END) begin
      q     = p - RD_START;
      grp   = GRP_RD;
      slot  = SLOT_W'(q >> 1);
      phase = q[0];
    end
  end

endmodule

// File: rtl/tdmseq_addr_gen.sv
module tdmseq_addr_gen
  import tdmseq_pkg::*;
#(
  parameter int unsigned N_FAST    = 8,
  parameter int unsigned N_SLOW    = 16,
  parameter int unsigned N_CHAN    = 128,
  parameter int unsigned SLOW_CHAN = 32,
  parameter int unsigned FAST_LEAD = 8,
  parameter int unsigned SLOW_LEAD = 2,
  parameter int unsigned CH_W      = 7,
  parameter int unsigned SLOT_W    = 4
) (
  input  grp_e              grp,
  input  logic [SLOT_W-1:0] slot,
  input  logic [CH_W-1:0]   chan,
  input  logic              wr_half,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_wrap
);

  localparam int unsigned ROT          = N_CHAN / SLOW_CHAN;
  localparam int unsigned SLOW_PER_GRP = N_SLOW / ROT;

  int unsigned s_i, c_i, lane, base_ch, span, lead, width, tgt;
  logic is_rd, is_fast, half;

  always_comb begin
    s_i     = 32'(slot);
    c_i     = 32'(chan);
    is_rd   = (grp == GRP_RD);
    is_fast = (s_i < N_FAST);
    if (is_fast) begin
      lane    = s_i;
      base_ch = c_i;
      span    = N_CHAN;
      lead    = FAST_LEAD;
      width   = N_FAST;
    end else begin
      lane    = (c_i % ROT) * SLOW_PER_GRP + (s_i - N_FAST);
      base_ch = c_i / ROT;
      span    = SLOW_CHAN;
      lead    = SLOW_LEAD;
      width   = N_SLOW;
    end
    tgt     = base_ch + (is_rd ? lead : 32'd0);
    rd_wrap = is_rd && (tgt >= span);
    if (rd_wrap) tgt = tgt - span;
    half = is_rd ? (rd_wrap ? wr_half : ~wr_half) : wr_half;
    addr = region_addr(half, is_rd, is_fast, tgt * width + lane);
  end

endmodule

// File: rtl/tdm_mem_seq.sv
module tdm_mem_seq
  import tdmseq_pkg::*;
#(
  parameter int unsigned N_FAST    = 8,
  parameter int unsigned N_SLOW    = 16,
  parameter int unsigned N_CHAN    = 128,
  parameter int unsigned SLOW_CHAN = 32,
  parameter int unsigned CHAN_CYC  = 64,
  parameter int unsigned GAP_CYC   = 4,
  parameter int unsigned FAST_LEAD = 8,
  parameter int unsigned SLOW_LEAD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_sync,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_stb_n,
  output logic              mem_qual_a,
  output logic              mem_qual_b,
  output logic              wr_half
);

  localparam int unsigned ROT          = N_CHAN / SLOW_CHAN;
  localparam int unsigned SLOW_PER_GRP = N_SLOW / ROT;
  localparam int unsigned N_ACC        = N_FAST + SLOW_PER_GRP;
  localparam int unsigned POS_W        = $clog2(CHAN_CYC);
  localparam int unsigned CH_W         = $clog2(N_CHAN);
  localparam int unsigned SLOT_W       = $clog2(N_ACC);

  // Named internal events, visible to the bound checker.
  logic [POS_W-1:0]  pos;
  logic [CH_W-1:0]   chan;
  logic              half_cur;
  logic              frame_bnd;
  grp_e              grp;
  logic [SLOT_W-1:0] slot;
  logic              phase;
  logic [ADDR_W-1:0] addr_nxt;
  logic              rd_wrap;

  tdmseq_timebase #(
    .CHAN_CYC(CHAN_CYC), .N_CHAN(N_CHAN), .POS_W(POS_W), .CH_W(CH_W)
  ) tb_i (
    .clk(clk), .rst_n(rst_n), .frm_sync(frm_sync),
    .pos(pos), .chan(chan), .half_cur(half_cur), .frame_bnd(frame_bnd)
  );

  tdmseq_slot_dec #(
    .N_ACC(N_ACC), .GAP_CYC(GAP_CYC), .POS_W(POS_W), .SLOT_W(SLOT_W)
  ) dec_i (
    .pos(pos), .grp(grp), .slot(slot), .phase(phase)
  );

  tdmseq_addr_gen #(
    .N_FAST(N_FAST), .N_SLOW(N_SLOW), .N_CHAN(N_CHAN), .SLOW_CHAN(SLOW_CHAN),
    .FAST_LEAD(FAST_LEAD), .SLOW_LEAD(SLOW_LEAD), .CH_W(CH_W), .SLOT_W(SLOT_W)
  ) ag_i (
    .grp(grp), .slot(slot), .chan(chan), .wr_half(half_cur),
    .addr(addr_nxt), .rd_wrap(rd_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_stb_n  <= 1'b1;
      mem_qual_a <= 1'b1;
      mem_qual_b <= 1'b1;
      wr_half    <= 1'b0;
    end else begin
      wr_half <= half_cur;
      case (grp)
        GRP_WR: begin
          mem_addr   <= addr_nxt;
          mem_stb_n  <= phase;
          mem_qual_a <= phase;
          mem_qual_b <= 1'b1;
        end
        GRP_RD: begin
          mem_addr   <= addr_nxt;
          mem_stb_n  <= 1'b0;
          mem_qual_a <= 1'b1;
          mem_qual_b <= 1'b0;
        end
        default: begin
          mem_addr   <= '0;
          mem_stb_n  <= 1'b1;
          mem_qual_a <= 1'b1;
          mem_qual_b <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/tdmseq_chk.sv
module tdmseq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] addr,
  input logic        stb_n,
  input logic        qa,
  input logic        qb,
  input logic        wr_half,
  input logic        frame_bnd,
  input logic        half_cur,
  input logic        rd_wrap
);

  // R3
  write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_n && !qa) |=> (stb_n && qa && qb && $stable(addr)));

  // R3
  write_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_n && !qa) |-> qb);

  // R4
  read_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qb |-> (!stb_n && qa));

  // R6
  write_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_n && !qa) |-> (addr[12] == wr_half && addr[11]));

  // R7
  read_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qb |-> !addr[11]);

  // R7
  read_wrap_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wrap |=> (addr[12] == wr_half));

  // R8
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bnd |=> (half_cur != $past(half_cur)));

endmodule

bind tdm_mem_seq tdmseq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(mem_addr), .stb_n(mem_stb_n),
  .qa(mem_qual_a), .qb(mem_qual_b), .wr_half(wr_half),
  .frame_bnd(frame_bnd), .half_cur(half_cur), .rd_wrap(rd_wrap)
);

// File: tb/tdm_mem_seq_tb_top.sv
module tdm_mem_seq_tb_top;

  localparam int CC    = 64;
  localparam int NCH   = 128;
  localparam int FRAME = CC * NCH;
  localparam int NTAB  = 13;

  // Spot vectors for frame 0 (write half 0): position, {addr, stb_n, qual_a, qual_b}
  localparam int          TAB_K [NTAB] = '{0, 1, 16, 24, 28, 44, 52, 336,
                                           7658, 7722, 8142, 8156, 8178};
  localparam logic [15:0] TAB_V [NTAB] = '{16'h6001, 16'h6007, 16'h4001, 16'h0007,
                                           16'hA202, 16'h8102, 16'h0007, 16'h40A1,
                                           16'hBFFA, 16'h203A, 16'h7FF9, 16'h21C2,
                                           16'h00FA};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_sync = 1'b0;
  logic [12:0] mem_addr;
  logic        mem_stb_n, mem_qual_a, mem_qual_b, wr_half;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  tdm_mem_seq dut_i (
    .clk(clk), .rst_n(rst_n), .frm_sync(frm_sync),
    .mem_addr(mem_addr), .mem_stb_n(mem_stb_n),
    .mem_qual_a(mem_qual_a), .mem_qual_b(mem_qual_b), .wr_half(wr_half)
  );

  function automatic logic [15:0] obs();
    return {mem_addr, mem_stb_n, mem_qual_a, mem_qual_b};
  endfunction

  // Reference port values for frame position k with write half h.
  function automatic logic [15:0] ref_out(int k, logic h);
    int ch, p, s, st, c2;
    logic hh;
    logic [12:0] a;
    ch = k / CC;
    p  = k % CC;
    if (p < 24) begin
      s = p / 2;
      if (s < 8) a = {h, 2'b11, 7'(ch), 3'(s)};
      else begin
        st = (ch % 4) * 4 + (s - 8);
        a  = {h, 2'b10, 1'b0, 5'(ch / 4), 4'(st)};
      end
      return {a, 1'(p % 2), 1'(p % 2), 1'b1};
    end else if (p >= 28 && p < 52) begin
      s = (p - 28) / 2;
      if (s < 8) begin
        c2 = ch + 8;
        hh = (c2 >= 128) ? h : ~h;
        a  = {hh, 2'b01, 7'(c2 % 128), 3'(s)};
      end else begin
        st = (ch % 4) * 4 + (s - 8);
        c2 = ch / 4 + 2;
        hh = (c2 >= 32) ? h : ~h;
        a  = {hh, 2'b00, 1'b0, 5'(c2 % 32), 4'(st)};
      end
      return {a, 3'b010};
    end
    return 16'h0007;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got addr=%h ctl=%b, expected addr=%h ctl=%b",
               tag, act[15:3], act[2:0], exp[15:3], exp[2:0]);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b, expected %b", tag, act, exp);
    end
  endtask

  task automatic run_span(int k0, int k1, logic h, string tag);
    for (int k = k0; k <= k1; k++) begin
      @(posedge clk); #1;
      check(tag, obs(), ref_out(k, h));
    end
  endtask

  initial begin
    int ti;
    ti = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset outputs", obs(), 16'h0007);
    check_bit("R1 reset half", wr_half, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // Frame 0: full trace plus table spot vectors
    for (int k = 0; k < FRAME; k++) begin
      @(posedge clk); #1;
      check("R2 R3 R4 R5 R6 R7 R10 frame0", obs(), ref_out(k, 1'b0));
      if (k == 0) check_bit("R1 first half", wr_half, 1'b0);
      if (ti < NTAB && k == TAB_K[ti]) begin
        check("R5 R6 R7 table vector", obs(), TAB_V[ti]);
        ti++;
      end
    end

    // Frame 1: natural wrap swaps the halves
    @(posedge clk); #1;
    check("R8 frame1 start", obs(), ref_out(0, 1'b1));
    check_bit("R8 half after wrap", wr_half, 1'b1);
    run_span(1, FRAME - 1, 1'b1, "R8 frame1");

    // Frame 2 (half 0), then a sync pulse in mid-frame
    run_span(0, 99, 1'b0, "R8 frame2");
    @(negedge clk) frm_sync = 1'b1;
    @(posedge clk); #1;
    check("R9 pre-sync position", obs(), ref_out(100, 1'b0));
    @(negedge clk) frm_sync = 1'b0;
    @(posedge clk); #1;
    check("R9 restart after sync", obs(), 16'hE001);
    check_bit("R9 half after sync", wr_half, 1'b1);
    run_span(1, FRAME - 2, 1'b1, "R9 after sync");

    // Sync on the last clock of the frame: a single toggle
    @(negedge clk) frm_sync = 1'b1;
    @(posedge clk); #1;
    check("R9 last position", obs(), ref_out(FRAME - 1, 1'b1));
    @(negedge clk) frm_sync = 1'b0;
    @(posedge clk); #1;
    check("R9 coincident sync", obs(), ref_out(0, 1'b0));
    check_bit("R9 single toggle", wr_half, 1'b0);
    run_span(1, 60, 1'b0, "R9 after coincident");

    // Reset in mid-run
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", obs(), 16'h0007);
    check_bit("R1 mid-run reset half", wr_half, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    run_span(0, 70, 1'b0, "R1 restart");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule